// File: doc/BRIEF.md
# Overlay Window Timing Generator

This block produces the read-side timing for a reduced-size inset picture laid over a parent video raster. It counts read-clock cycles from the parent line sync and lines from the parent field sync. From these counts it finds a rectangular picture region whose corner is programmable and whose size follows the line standard and decimation setting. It also finds a ring of programmable thickness around that rectangle. Inside the picture it requests memory data and gives the stored pixel and line index. Inside the ring it flags the border and drives a fixed border color. It also drives a select output for an external video switch. The select output is the union of picture and ring, shifted by a signed number of clocks.

The configuration inputs go through a shadow register. That register loads only on a field sync, so a field never shows a mix of old and new settings. In line-doubling mode each stored line is requested on two consecutive raster lines. This serves progressive parent rasters.

Top module: `pip_overlay_timing`

## Requirements
- R1: During and directly after reset, `rd_en`, `bord_act`, `sel` and all color and index outputs are zero.
- R2: The column count is 0 in the cycle after the edge that samples `hsync`. The picture starts at column 52 + `hpos`, so `hpos` = 2 puts the first pixel 54 read clocks after the line sync. Every output lags the counters by a fixed 8 clocks.
- R3: The line count is 0 after the edge that samples `vsync` and rises by one on each `hsync`. The picture starts on line 4 + `vpos`.
- R4: The picture width is 212 columns when `hdec4`=0 and 160 when `hdec4`=1. The stored height is 88 (`std_525`=0, `vdec4`=0), 76 (1,0), 66 (0,1) or 57 (1,1) lines.
- R5: When `line_dbl`=1, the displayed height is twice the stored height. `rd_line` is (line − first line) shifted right by one, so each stored line index appears on two consecutive lines. When `line_dbl`=0 it is not shifted.
- R6: `bord_act` is high in a ring outside the picture. The ring is `bord_w_h` columns (0..7) on the left and on the right, and `bord_w_v` lines (0..3) on the top and on the bottom. It is never high together with `rd_en`. A width of zero gives no ring on that axis.
- R7: While `bord_act` is high, each 6-bit color output is its 4-bit code followed by two zero bits ({code, 2'b00}). Otherwise all color outputs are zero.
- R8: `sel` is high for picture or ring. It is shifted by `sel_phase` clocks relative to `rd_en`. `sel_phase` is a 4-bit two's-complement value from −8 to +7; a positive value makes `sel` later and 0 aligns `sel` with `rd_en`.
- R9: All configuration inputs take effect only on the edge that samples `vsync`. Changes at any other time have no effect on the outputs.
- R10: While the shadowed `pip_en` is 0, `rd_en`, `bord_act` and `sel` stay low.
- R11: `rd_pix` counts 0, 1, 2, ... across the picture row, starting at the first picture column. `rd_pix` and `rd_line` are zero outside the picture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Parent line sync, one-cycle pulse |
| vsync | input | 1 | Parent field sync, one-cycle pulse |
| pip_en | input | 1 | Overlay enable |
| hpos | input | 10 | Horizontal picture position, 1 column per step |
| vpos | input | 8 | Vertical picture position, 1 line per step |
| std_525 | input | 1 | Inset line standard: 0 = 625 lines, 1 = 525 lines |
| hdec4 | input | 1 | Horizontal decimation 4:1 (0 selects 3:1) |
| vdec4 | input | 1 | Vertical decimation 4:1 (0 selects 3:1) |
| line_dbl | input | 1 | Request each stored line on two lines |
| bord_w_h | input | 3 | Ring width in columns |
| bord_w_v | input | 2 | Ring height in lines |
| bord_y | input | 4 | Ring luminance code |
| bord_u | input | 4 | Ring blue color-difference code |
| bord_v | input | 4 | Ring red color-difference code |
| sel_phase | input | 4 | Signed shift of `sel` in clocks |
| rd_en | output | 1 | Picture memory read request |
| rd_pix | output | 8 | Stored pixel index |
| rd_line | output | 7 | Stored line index |
| bord_act | output | 1 | Ring active |
| out_y | output | 6 | Ring luminance value |
| out_u | output | 6 | Ring blue color-difference value |
| out_v | output | 6 | Ring red color-difference value |
| sel | output | 1 | External switch select |

## Verification
Some properties are checked on every cycle by assertions: the ring and the picture never overlap, the colors are zero outside the ring and always have clear low bits, the pixel index steps by one along a picture row, the line index holds within a row, and the outputs are clean after reset. Other behaviour only the bench scenarios can show. This covers the exact start column and line for each position, each size from the height table, line doubling, the ring extent at zero and maximum widths, and the `sel` shift at both signed extremes. It also covers configuration changes in mid-field that must have no effect, and a field with the overlay disabled.

// File: rtl/pip_pos_pkg.sv
package pip_pos_pkg;
    localparam int HCW  = 11;
    localparam int VCW  = 10;
    localparam int HPW  = 10;
    localparam int VPW  = 8;
    localparam int PIXW = 8;
    localparam int LINW = 7;
    localparam int CW   = 4;
    localparam int OW   = 6;
    localparam int PHW  = 4;
    localparam int LAT  = 1 << (PHW - 1);
    localparam int TAPS = 1 << PHW;
    localparam int HOFS = 52;
    localparam int VOFS = 4;
    localparam int W_DEC3 = 212;
    localparam int W_DEC4 = 160;
    localparam int H_625_3 = 88;
    localparam int H_525_3 = 76;
    localparam int H_625_4 = 66;
    localparam int H_525_4 = 57;

    typedef struct packed {
        logic                  en;
        logic [HPW-1:0]        hpos;
        logic [VPW-1:0]        vpos;
        logic                  std525;
        logic                  hdec4;
        logic                  vdec4;
        logic                  dbl;
        logic [2:0]            bwh;
        logic [1:0]            bwv;
        logic [CW-1:0]         cy;
        logic [CW-1:0]         cu;
        logic [CW-1:0]         cv;
        logic signed [PHW-1:0] phase;
    } cfg_t;

    typedef struct packed {
        logic            pic;
        logic            brd;
        logic [PIXW-1:0] pix;
        logic [LINW-1:0] line;
        logic [OW-1:0]   y;
        logic [OW-1:0]   u;
        logic [OW-1:0]   v;
    } px_t;

    function automatic logic [8:0] pic_width(input logic hdec4);
        return hdec4 ? 9'(W_DEC4) : 9'(W_DEC3);
    endfunction

    function automatic logic [8:0] pic_height(input logic std525, input logic vdec4,
                                              input logic dbl);
        logic [8:0] base;
        case ({vdec4, std525})
            2'b00:   base = 9'(H_625_3);
            2'b01:   base = 9'(H_525_3);
            2'b10:   base = 9'(H_625_4);
            default: base = 9'(H_525_4);
        endcase
        return dbl ? (base << 1) : base;
    endfunction

    function automatic logic [OW-1:0] widen_code(input logic [CW-1:0] c);
        return {c, {(OW-CW){1'b0}}};
    endfunction
endpackage

// File: rtl/pip_cfg_shadow.sv
module pip_cfg_shadow
    import pip_pos_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vsync,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (vsync)
            cfg_q <= cfg_in;
    end
endmodule

// File: rtl/pip_raster_cnt.sv
module pip_raster_cnt
    import pip_pos_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hsync,
    input  logic           vsync,
    output logic [HCW-1:0] hcnt,
    output logic [VCW-1:0] vcnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '1;
            vcnt <= '1;
        end else begin
            if (hsync)
                hcnt <= '0;
            else if (hcnt != '1)
                hcnt <= hcnt + 1'b1;
            if (vsync)
                vcnt <= '0;
            else if (hsync && (vcnt != '1))
                vcnt <= vcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pip_window_decode.sv
module pip_window_decode
    import pip_pos_pkg::*;
(
    input  cfg_t           cfg,
    input  logic [HCW-1:0] hcnt,
    input  logic [VCW-1:0] vcnt,
    output px_t            px,
    output logic           win
);
    logic [HCW:0] h_c, h_s, h_e, h_b;
    logic [VCW:0] v_c, v_s, v_e, v_b, v_d;
    logic in_hp, in_ho, in_vp, in_vo, pic, outer, brd;

    always_comb begin
        h_c = {1'b0, hcnt};
        h_s = (HCW+1)'(HOFS) + (HCW+1)'(cfg.hpos);
        h_e = h_s + (HCW+1)'(pic_width(cfg.hdec4));
        h_b = (HCW+1)'(cfg.bwh);
        v_c = {1'b0, vcnt};
        v_s = (VCW+1)'(VOFS) + (VCW+1)'(cfg.vpos);
        v_e = v_s + (VCW+1)'(pic_height(cfg.std525, cfg.vdec4, cfg.dbl));
        v_b = (VCW+1)'(cfg.bwv);
        v_d = v_c - v_s;

        in_hp = (h_c >= h_s) && (h_c < h_e);
        in_ho = ((h_c + h_b) >= h_s) && (h_c < (h_e + h_b));
        in_vp = (v_c >= v_s) && (v_c < v_e);
        in_vo = ((v_c + v_b) >= v_s) && (v_c < (v_e + v_b));

        pic   = cfg.en && in_hp && in_vp;
        outer = cfg.en && in_ho && in_vo;
        brd   = outer && !pic;

        px.pic  = pic;
        px.brd  = brd;
        px.pix  = pic ? PIXW'(h_c - h_s) : '0;
        px.line = pic ? LINW'(cfg.dbl ? (v_d >> 1) : v_d) : '0;
        px.y    = brd ? widen_code(cfg.cy) : '0;
        px.u    = brd ? widen_code(cfg.cu) : '0;
        px.v    = brd ? widen_code(cfg.cv) : '0;
        win     = outer;
    end
endmodule

// File: rtl/pip_out_pipe.sv
module pip_out_pipe
    import pip_pos_pkg::*;
#(
    parameter int DEPTH = LAT
) (
    input  logic clk,
    input  logic rst,
    input  px_t  d,
    output px_t  q
);
    px_t stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/pip_sel_tap.sv
module pip_sel_tap
    import pip_pos_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  win,
    input  logic signed [PHW-1:0] phase,
    output logic                  sel
);
    logic [TAPS-1:1] sh;
    logic [TAPS-1:0] taps;
    logic [PHW-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[TAPS-2:1], win};
    end

    assign taps = {sh, win};
    assign idx  = PHW'(LAT) + $unsigned(phase);
    assign sel  = taps[idx];
endmodule

// File: rtl/pip_overlay_timing.sv
module pip_overlay_timing
    import pip_pos_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hsync,
    input  logic        vsync,
    input  logic        pip_en,
    input  logic [9:0]  hpos,
    input  logic [7:0]  vpos,
    input  logic        std_525,
    input  logic        hdec4,
    input  logic        vdec4,
    input  logic        line_dbl,
    input  logic [2:0]  bord_w_h,
    input  logic [1:0]  bord_w_v,
    input  logic [3:0]  bord_y,
    input  logic [3:0]  bord_u,
    input  logic [3:0]  bord_v,
    input  logic [3:0]  sel_phase,
    output logic        rd_en,
    output logic [7:0]  rd_pix,
    output logic [6:0]  rd_line,
    output logic        bord_act,
    output logic [5:0]  out_y,
    output logic [5:0]  out_u,
    output logic [5:0]  out_v,
    output logic        sel
);
    cfg_t           cfg_in, cfg_q;
    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;
    px_t            px_d, px_q;
    logic           win;

    always_comb begin
        cfg_in.en     = pip_en;
        cfg_in.hpos   = hpos;
        cfg_in.vpos   = vpos;
        cfg_in.std525 = std_525;
        cfg_in.hdec4  = hdec4;
        cfg_in.vdec4  = vdec4;
        cfg_in.dbl    = line_dbl;
        cfg_in.bwh    = bord_w_h;
        cfg_in.bwv    = bord_w_v;
        cfg_in.cy     = bord_y;
        cfg_in.cu     = bord_u;
        cfg_in.cv     = bord_v;
        cfg_in.phase  = $signed(sel_phase);
    end

    pip_cfg_shadow u_shadow (
        .clk(clk), .rst(rst), .vsync(vsync), .cfg_in(cfg_in), .cfg_q(cfg_q)
    );

    pip_raster_cnt u_cnt (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .hcnt(hcnt), .vcnt(vcnt)
    );

    pip_window_decode u_dec (
        .cfg(cfg_q), .hcnt(hcnt), .vcnt(vcnt), .px(px_d), .win(win)
    );

    pip_out_pipe #(.DEPTH(LAT)) u_pipe (
        .clk(clk), .rst(rst), .d(px_d), .q(px_q)
    );

    pip_sel_tap u_sel (
        .clk(clk), .rst(rst), .win(win), .phase(cfg_q.phase), .sel(sel)
    );

    assign rd_en    = px_q.pic;
    assign rd_pix   = px_q.pix;
    assign rd_line  = px_q.line;
    assign bord_act = px_q.brd;
    assign out_y    = px_q.y;
    assign out_u    = px_q.u;
    assign out_v    = px_q.v;
endmodule

// File: rtl/pip_overlay_timing_chk.sv
module pip_overlay_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_en,
    input logic [7:0] rd_pix,
    input logic [6:0] rd_line,
    input logic       bord_act,
    input logic [5:0] out_y,
    input logic [5:0] out_u,
    input logic [5:0] out_v,
    input logic       sel
);
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_en && !bord_act && !sel));

    a_r6_ring_excludes_picture: assert property (@(posedge clk) disable iff (rst)
        bord_act |-> !rd_en);

    a_r7_colors_off_outside: assert property (@(posedge clk) disable iff (rst)
        !bord_act |-> (out_y == 6'd0 && out_u == 6'd0 && out_v == 6'd0));

    a_r7_low_bits_clear: assert property (@(posedge clk) disable iff (rst)
        (out_y[1:0] | out_u[1:0] | out_v[1:0]) == 2'b00);

    a_r11_pix_steps: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (9'(rd_pix) == 9'($past(rd_pix)) + 9'd1));

    a_r5_line_holds_in_row: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_line == $past(rd_line)));

    a_r4_pix_in_width: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_pix < 8'd212));
endmodule

bind pip_overlay_timing pip_overlay_timing_chk i_chk (.*);

// File: tb/test_pip_overlay_timing.sv
module test_pip_overlay_timing;
    localparam int CLK_P  = 10;
    localparam int LINE_P = 290;
    localparam int WDOG   = 195000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync = 0, vsync = 0, pip_en = 0, std_525 = 0, hdec4 = 0, vdec4 = 0, line_dbl = 0;
    logic [9:0] hpos = '0;
    logic [7:0] vpos = '0;
    logic [2:0] bord_w_h = '0;
    logic [1:0] bord_w_v = '0;
    logic [3:0] bord_y = '0, bord_u = '0, bord_v = '0, sel_phase = '0;
    logic       rd_en, bord_act, sel;
    logic [7:0] rd_pix;
    logic [6:0] rd_line;
    logic [5:0] out_y, out_u, out_v;

    always #(CLK_P/2) clk = ~clk;

    pip_overlay_timing i_pip_overlay_timing (.*);

    int total = 0, bad = 0;
    string ftag = "";

    // reference model state
    int hc = 2047, vc = 1023;
    int s_en = 0, s_hpos = 0, s_vpos = 0, s_std = 0, s_hd = 0, s_vd = 0, s_dbl = 0;
    int s_bwh = 0, s_bwv = 0, s_cy = 0, s_cu = 0, s_cv = 0, s_ph = 0;
    int e_pic[16], e_brd[16], e_pix[16], e_line[16], e_y[16], e_u[16], e_v[16], e_win[16];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", what, ftag, act, exp, $time);
        end
    endtask

    function automatic int base_h(input int std, input int vd);
        if (vd == 0) return (std == 0) ? 88 : 76;
        return (std == 0) ? 66 : 57;
    endfunction

    function automatic int frame_lines();
        int hh = base_h(int'(std_525), int'(vdec4)) * (line_dbl ? 2 : 1);
        return 4 + int'(vpos) + hh + int'(bord_w_v) + 2;
    endfunction

    task automatic model_step(input bit hs, input bit vs);
        int hs0, he, vs0, ve, pic, outer;
        if (vs) begin
            s_en = pip_en; s_hpos = hpos; s_vpos = vpos; s_std = std_525; s_hd = hdec4;
            s_vd = vdec4; s_dbl = line_dbl; s_bwh = bord_w_h; s_bwv = bord_w_v;
            s_cy = bord_y; s_cu = bord_u; s_cv = bord_v;
            s_ph = (sel_phase >= 8) ? int'(sel_phase) - 16 : int'(sel_phase);
        end
        if (vs) vc = 0; else if (hs && vc < 1023) vc++;
        if (hs) hc = 0; else if (hc < 2047) hc++;
        for (int k = 15; k > 0; k--) begin
            e_pic[k] = e_pic[k-1]; e_brd[k] = e_brd[k-1]; e_pix[k] = e_pix[k-1];
            e_line[k] = e_line[k-1]; e_y[k] = e_y[k-1]; e_u[k] = e_u[k-1];
            e_v[k] = e_v[k-1]; e_win[k] = e_win[k-1];
        end
        hs0 = 52 + s_hpos;
        he  = hs0 + (s_hd ? 160 : 212);
        vs0 = 4 + s_vpos;
        ve  = vs0 + base_h(s_std, s_vd) * (s_dbl ? 2 : 1);
        pic   = (s_en != 0) && hc >= hs0 && hc < he && vc >= vs0 && vc < ve;
        outer = (s_en != 0) && hc + s_bwh >= hs0 && hc < he + s_bwh &&
                vc + s_bwv >= vs0 && vc < ve + s_bwv;
        e_pic[0]  = pic;
        e_brd[0]  = outer && !pic;
        e_win[0]  = outer;
        e_pix[0]  = pic ? hc - hs0 : 0;
        e_line[0] = pic ? ((vc - vs0) >> s_dbl) : 0;
        e_y[0] = e_brd[0] ? s_cy * 4 : 0;
        e_u[0] = e_brd[0] ? s_cu * 4 : 0;
        e_v[0] = e_brd[0] ? s_cv * 4 : 0;
    endtask

    // called at a falling edge; drives syncs, steps model, compares after next edge
    task automatic tick(input bit hs, input bit vs);
        hsync = hs; vsync = vs;
        model_step(hs, vs);
        @(posedge clk);
        @(negedge clk);
        chk(rd_en == e_pic[8], "R2 R3 R4 R10 rd_en", rd_en, e_pic[8]);
        chk(rd_pix == e_pix[8], "R11 rd_pix", rd_pix, e_pix[8]);
        chk(rd_line == e_line[8], "R5 rd_line", rd_line, e_line[8]);
        chk(bord_act == e_brd[8], "R6 bord_act", bord_act, e_brd[8]);
        chk(out_y == e_y[8] && out_u == e_u[8] && out_v == e_v[8], "R7 color",
            {out_y, out_u, out_v}, (e_y[8] << 12) | (e_u[8] << 6) | e_v[8]);
        chk(sel == e_win[8 + s_ph], "R8 sel", sel, e_win[8 + s_ph]);
    endtask

    task automatic scramble();
        pip_en = $urandom; hpos = $urandom; vpos = $urandom; std_525 = $urandom;
        hdec4 = $urandom; vdec4 = $urandom; line_dbl = $urandom; bord_w_h = $urandom;
        bord_w_v = $urandom; bord_y = $urandom; bord_u = $urandom; bord_v = $urandom;
        sel_phase = $urandom;
    endtask

    task automatic rand_cfg(input bit dbl);
        pip_en = 1; hpos = 10'(2 + $urandom % 15); vpos = 8'($urandom % 9);
        std_525 = $urandom; hdec4 = $urandom; vdec4 = $urandom; line_dbl = dbl;
        bord_w_h = $urandom; bord_w_v = $urandom; bord_y = $urandom;
        bord_u = $urandom; bord_v = $urandom; sel_phase = $urandom;
    endtask

    task automatic run_frame(input int nlines, input bit mix);
        for (int l = 0; l < nlines; l++) begin
            if (mix && l == 2) scramble();   // R9: must not act before next vsync
            tick(1'b1, l == 0);
            for (int c = 1; c < LINE_P; c++) tick(1'b0, 1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 16; k++) begin
            e_pic[k] = 0; e_brd[k] = 0; e_pix[k] = 0; e_line[k] = 0;
            e_y[k] = 0; e_u[k] = 0; e_v[k] = 0; e_win[k] = 0;
        end
        repeat (4) @(negedge clk);
        ftag = "reset";
        chk(rd_en == 0 && bord_act == 0 && sel == 0, "R1 control outputs", rd_en, 0);
        chk(rd_pix == 0 && rd_line == 0, "R1 index outputs", rd_pix, 0);
        chk(out_y == 0 && out_u == 0 && out_v == 0, "R1 colors", out_y, 0);
        rst = 1'b0;

        // earliest position, widest ring, sel aligned (R2 R3 R6 R8)
        ftag = "F0 hpos=2 vpos=0 ring 7x3";
        pip_en = 1; hpos = 2; vpos = 0; std_525 = 0; hdec4 = 0; vdec4 = 0; line_dbl = 0;
        bord_w_h = 7; bord_w_v = 3; bord_y = 4'hF; bord_u = 4'h5; bord_v = 4'hA; sel_phase = 0;
        run_frame(frame_lines(), 1'b1);

        // 525/4:1 doubled, no ring, most negative sel shift (R4 R5 R6 R8 R9)
        ftag = "F1 525 dec4 doubled ring 0 phase -8";
        pip_en = 1; hpos = 16; vpos = 8; std_525 = 1; hdec4 = 1; vdec4 = 1; line_dbl = 1;
        bord_w_h = 0; bord_w_v = 0; bord_y = 4'h3; bord_u = 4'hC; bord_v = 4'h1; sel_phase = 4'h8;
        run_frame(frame_lines(), 1'b1);

        ftag = "F2 random phase +7 R9";
        rand_cfg(1'b0); sel_phase = 4'h7;
        run_frame(frame_lines(), 1'b1);

        ftag = "F3 random doubled R5 R9";
        rand_cfg(1'b1);
        run_frame(frame_lines(), 1'b1);

        ftag = "F4 disabled R10";
        rand_cfg(1'b0); pip_en = 0;
        run_frame(20, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * WDOG);
        total++; bad++;
        $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule